// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This block is the final stage of a floating-point datapath. An arithmetic unit hands it a result in unpacked form: a sign, a signed unbiased exponent and a 56-bit mantissa. The mantissa holds the hidden bit at bit 55, then 52 fraction bits, then three extra low bits for guard, round and sticky. The block rounds this value under the selected rounding mode and brings it back into range. It then packs it into a 64-bit IEEE 754 double and reports the inexact, underflow and overflow exception flags.

Results whose exponent falls below the minimum are shifted into subnormal form, with the shifted-out bits folded into sticky. An optional flush-to-zero control replaces such results with zero or with the smallest subnormal, depending on the rounding direction. Tininess is judged before rounding, with one exception. If the exponent is one below the minimum and rounding would carry the value back into the normal range, the result is not tiny.

The input is qualified by a valid strobe. The packed word and the flags are registered and appear one clock later, together with an output valid. The caller must not present zero, NaN or infinity operands.

Top module: `dp_round_pack`

## Requirements
- R1: While rst_ni is low, valid_o, result_o and the three flags are all zero.
- R2: valid_o is high in exactly the cycle after a cycle with valid_i high, and result_o and the flags belong to that input.
- R3: The rounding mode rmode_i is encoded as 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. Rounding acts only when mant_i[2:0] is nonzero. Nearest-even adds 3 plus bit 3, toward +infinity adds 8 when sign_i is 0, toward -infinity adds 8 when sign_i is 1, and toward zero adds nothing.
- R4: If rounding carries above bit 55, the mantissa shifts right by one and the exponent rises by one.
- R5: A result whose three low bits are zero, whose exponent lies in [-1022, 1023] and which needs no flush raises no flag.
- R6: Below an exponent of -1022, the mantissa is shifted right by (-1022 - exponent), with a sticky OR into bit 0, and the exponent is set to -1022. Whenever the low bits are then nonzero, inexact is raised, and underflow is raised too if bit 55 is clear.
- R7: An exponent of -1023 whose rounded mantissa carries out is rounded, shifted right by one and given zero low bits. The result is the normal value at exponent -1022, with inexact set and underflow clear.
- R8: With ftz_i high and an exponent below -1022, inexact and underflow are raised. The result is the smallest subnormal with sign_i for toward +infinity with a positive sign, or for toward -infinity with a negative sign, and a zero with sign_i otherwise. ftz_i has no effect for exponents of -1022 or above.
- R9: If the exponent after rounding exceeds 1023, overflow and inexact are raised. The result is infinity with sign_i for nearest-even, for toward +infinity with a positive sign and for toward -infinity with a negative sign. Otherwise it is the largest finite value (field 0x7FE, fraction all ones) with sign_i.
- R10: result_o holds the sign in bit 63, the exponent field in bits 62:52 and the fraction in bits 51:0. A rounded value with bit 55 clear packs with a zero exponent field. Otherwise the field is exponent + 1023 and the hidden bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operand valid |
| sign_i | input | 1 | Sign of the unpacked result |
| exp_i | input | 13 | Unbiased exponent, two's complement |
| mant_i | input | 56 | Hidden bit at 55, fraction, then guard/round/sticky |
| rmode_i | input | 2 | Rounding mode |
| ftz_i | input | 1 | Flush tiny results |
| valid_o | output | 1 | Output valid |
| result_o | output | 64 | Packed double |
| inexact_o | output | 1 | Inexact flag |
| underflow_o | output | 1 | Underflow flag |
| overflow_o | output | 1 | Overflow flag |

## Verification
The bench uses the default parameters, an 11-bit exponent field and a 52-bit fraction. With these values every expected word can be written as a real double, and the subnormal boundary sits at -1022. The exponent port is two bits wider than the field. This lets the bench drive exponents above 1023 and far below -1022, so shifts beyond the 56-bit mantissa exercise the pure-sticky path. It also reaches the -1023 carry exception, all four directions for both signs in overflow and flush, and a sweep of every shift distance from 1 to 60.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;
endpackage

// File: rtl/rp_rounder.sv
module rp_rounder #(
  parameter int unsigned MANT_W = 56
) (
  input  logic               sign_i,
  input  rp_pkg::rmode_e     mode_i,
  input  logic [MANT_W-1:0]  mant_i,
  output logic [MANT_W:0]    sum_o
);
  logic [3:0] inc;

  always_comb begin
    inc = 4'd0;
    if (|mant_i[2:0]) begin
      case (mode_i)
        rp_pkg::RM_NEAR: inc = 4'd3 + {3'd0, mant_i[3]};
        rp_pkg::RM_UP:   inc = sign_i ? 4'd0 : 4'd8;
        rp_pkg::RM_DOWN: inc = sign_i ? 4'd8 : 4'd0;
        default:         inc = 4'd0;
      endcase
    end
    sum_o = {1'b0, mant_i} + {{(MANT_W-3){1'b0}}, inc};
  end
endmodule

// File: rtl/rp_align.sv
module rp_align #(
  parameter int unsigned             MANT_W = 56,
  parameter int unsigned             XW     = 14,
  parameter logic signed [XW-1:0]    EMIN_S = XW'(-1022)
) (
  input  logic                  sign_i,
  input  rp_pkg::rmode_e        mode_i,
  input  logic signed [XW-1:0]  xe_i,
  input  logic [MANT_W-1:0]     mant_i,
  output logic [MANT_W-1:0]     mant_o,
  output logic signed [XW-1:0]  xe_o,
  output logic                  inexact_o
);
  localparam int unsigned          SH_W    = $clog2(MANT_W);
  localparam logic signed [XW-1:0] EMIN_M1 = XW'(EMIN_S - 1);

  logic signed [XW-1:0] es;
  logic                 tiny, big, lost;
  logic [SH_W-1:0]      es_c;
  logic [MANT_W-1:0]    shifted;
  logic [MANT_W:0]      probe;

  // trial rounding for the one-below-minimum exception
  rp_rounder #(.MANT_W(MANT_W)) u_probe (
    .sign_i (sign_i),
    .mode_i (mode_i),
    .mant_i (mant_i),
    .sum_o  (probe)
  );

  always_comb begin
    es      = EMIN_S - xe_i;
    tiny    = xe_i < EMIN_S;
    big     = es >= $signed(XW'(MANT_W));
    es_c    = es[SH_W-1:0];
    lost    = |(mant_i & ~({MANT_W{1'b1}} << es_c));
    shifted = big ? {{(MANT_W-1){1'b0}}, |mant_i}
                  : ((mant_i >> es_c) | {{(MANT_W-1){1'b0}}, lost});

    mant_o    = mant_i;
    xe_o      = xe_i;
    inexact_o = 1'b0;
    if (tiny) begin
      xe_o = EMIN_S;
      if (xe_i == EMIN_M1 && probe[MANT_W]) begin
        mant_o    = {probe[MANT_W:4], 3'b000};
        inexact_o = 1'b1;
      end else begin
        mant_o = shifted;
      end
    end
  end
endmodule

// File: rtl/rp_pack.sv
module rp_pack #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned XW     = 14
) (
  input  logic                       sign_i,
  input  rp_pkg::rmode_e             mode_i,
  input  logic                       ftz_hit_i,
  input  logic signed [XW-1:0]       xe_i,
  input  logic [FRAC_W:0]            mant_i,
  output logic [EXP_W+FRAC_W:0]      result_o,
  output logic                       ovf_o
);
  localparam int unsigned          TOT_W  = EXP_W + FRAC_W + 1;
  localparam logic signed [XW-1:0] BIAS_S = XW'((1 << (EXP_W - 1)) - 1);

  logic                 away;
  logic signed [XW-1:0] biased;
  logic [TOT_W-1:0]     inf_w, max_w, zero_w, mind_w;

  always_comb begin
    // rounding direction points away from zero for this sign
    away   = (mode_i == rp_pkg::RM_UP && !sign_i) || (mode_i == rp_pkg::RM_DOWN && sign_i);
    inf_w  = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    max_w  = {sign_i, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    zero_w = {sign_i, {(TOT_W-1){1'b0}}};
    mind_w = {sign_i, {(TOT_W-2){1'b0}}, 1'b1};
    biased = xe_i + BIAS_S;
    ovf_o  = !ftz_hit_i && (xe_i > BIAS_S);

    if (ftz_hit_i)
      result_o = away ? mind_w : zero_w;
    else if (ovf_o)
      result_o = (away || mode_i == rp_pkg::RM_NEAR) ? inf_w : max_w;
    else if (!mant_i[FRAC_W])
      result_o = {sign_i, {EXP_W{1'b0}}, mant_i[FRAC_W-1:0]};
    else
      result_o = {sign_i, biased[EXP_W-1:0], mant_i[FRAC_W-1:0]};
  end
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sign_i,
  input  logic [EXP_W+1:0]        exp_i,
  input  logic [FRAC_W+3:0]       mant_i,
  input  logic [1:0]              rmode_i,
  input  logic                    ftz_i,
  output logic                    valid_o,
  output logic [EXP_W+FRAC_W:0]   result_o,
  output logic                    inexact_o,
  output logic                    underflow_o,
  output logic                    overflow_o
);
  localparam int unsigned          MANT_W  = FRAC_W + 4;
  localparam int unsigned          TOT_W   = EXP_W + FRAC_W + 1;
  localparam int unsigned          XE_W    = EXP_W + 2;
  localparam int unsigned          XW      = XE_W + 1;
  localparam logic signed [XW-1:0] BIAS_S  = XW'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [XW-1:0] EMIN_S  = XW'(1 - BIAS_S);
  localparam logic signed [XW-1:0] EMIN_M1 = XW'(EMIN_S - 1);

  rp_pkg::rmode_e       md;
  logic signed [XW-1:0] xe_s, a_xe, r_xe;
  logic [MANT_W-1:0]    a_mant;
  logic                 a_ix;
  logic [MANT_W:0]      f_sum;
  logic                 carry, f_ix, f_uf, ftz_hit, ovf;
  logic [FRAC_W:0]      r_mant;
  logic [TOT_W-1:0]     packed_w;
  logic                 ix_n, uf_n, of_n;

  assign md      = rp_pkg::rmode_e'(rmode_i);
  assign xe_s    = {exp_i[XE_W-1], exp_i};
  assign ftz_hit = ftz_i && (xe_s < EMIN_S);

  rp_align #(.MANT_W(MANT_W), .XW(XW), .EMIN_S(EMIN_S)) u_align (
    .sign_i    (sign_i),
    .mode_i    (md),
    .xe_i      (xe_s),
    .mant_i    (mant_i),
    .mant_o    (a_mant),
    .xe_o      (a_xe),
    .inexact_o (a_ix)
  );

  rp_rounder #(.MANT_W(MANT_W)) u_round (
    .sign_i (sign_i),
    .mode_i (md),
    .mant_i (a_mant),
    .sum_o  (f_sum)
  );

  // tininess judged on the aligned value, before rounding
  assign f_ix   = |a_mant[2:0];
  assign f_uf   = f_ix && !a_mant[MANT_W-1];
  assign carry  = f_sum[MANT_W];
  assign r_mant = carry ? f_sum[MANT_W:4] : f_sum[MANT_W-1:3];
  assign r_xe   = a_xe + $signed({{(XW-1){1'b0}}, carry});

  rp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_pack (
    .sign_i    (sign_i),
    .mode_i    (md),
    .ftz_hit_i (ftz_hit),
    .xe_i      (r_xe),
    .mant_i    (r_mant),
    .result_o  (packed_w),
    .ovf_o     (ovf)
  );

  assign of_n = ovf;
  assign uf_n = ftz_hit || f_uf;
  assign ix_n = ftz_hit || a_ix || f_ix || ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o    <= packed_w;
        inexact_o   <= ix_n;
        underflow_o <= uf_n;
        overflow_o  <= of_n;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && overflow_o) |-> inexact_o); // R9
  AST_UFL_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && underflow_o) |-> (inexact_o && !overflow_o)); // R6
  AST_EXACT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mant_i[2:0] == 3'b000 && xe_s >= EMIN_S && xe_s <= BIAS_S)
    |=> (!inexact_o && !underflow_o && !overflow_o)); // R5
  AST_FTZ_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ftz_i && xe_s < EMIN_S)
    |=> (inexact_o && underflow_o && !overflow_o)); // R8
  AST_EDGE_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ftz_i && xe_s == EMIN_M1 && (&mant_i[MANT_W-1:3]) && mant_i[2]
     && md == rp_pkg::RM_NEAR)
    |=> (result_o[TOT_W-2 -: EXP_W] == EXP_W'(1) && inexact_o && !underflow_o)); // R7
endmodule

// File: tb/tb_dp_round_pack.sv
module tb_dp_round_pack;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [12:0] exp_i = '0;
  logic [55:0] mant_i = '0;
  logic [1:0]  rmode_i = 2'b00;
  logic        ftz_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        inexact_o, underflow_o, overflow_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2.5 clk_i = ~clk_i;

  dp_round_pack dut (
    .clk_i, .rst_ni, .valid_i, .sign_i, .exp_i, .mant_i, .rmode_i, .ftz_i,
    .valid_o, .result_o, .inexact_o, .underflow_o, .overflow_o
  );

  function automatic logic [56:0] ref_add(input logic s, input logic [56:0] x, input logic [1:0] md);
    if (x[2:0] == 3'b000) return 57'd0;
    case (md)
      2'b00:   return 57'd3 + {56'd0, x[3]};
      2'b10:   return s ? 57'd0 : 57'd8;
      2'b11:   return s ? 57'd8 : 57'd0;
      default: return 57'd0;
    endcase
  endfunction

  // reference model: returns {word, inexact, underflow, overflow}
  function automatic logic [66:0] ref_dp(input logic s, input int e, input logic [55:0] m,
                                         input logic [1:0] md, input logic fz);
    logic [56:0] x, t;
    logic [52:0] f;
    logic [63:0] r;
    logic        ix, uf, of, b, toward;
    int          ee;
    ix = 1'b0; uf = 1'b0; of = 1'b0;
    x  = {1'b0, m};
    ee = e;
    toward = (md == 2'b10 && !s) || (md == 2'b11 && s);
    if (e < -1022) begin
      if (fz) begin
        r = {s, 63'd0};
        if (toward) r[0] = 1'b1;
        return {r, 3'b110};
      end
      t = x + ref_add(s, x, md);
      if (e == -1023 && t[56]) begin
        x = t >> 1;
        x[2:0] = 3'b000;
        ix = 1'b1;
      end else begin
        for (int k = 0; k < -1022 - e && k < 60; k++) begin
          b = x[0];
          x = x >> 1;
          x[0] = x[0] | b;
        end
      end
      ee = -1022;
    end
    if (x[2:0] != 3'b000) begin
      ix = 1'b1;
      if (!x[55]) uf = 1'b1;
      x = x + ref_add(s, x, md);
      if (x[56]) begin
        x = x >> 1;
        ee = ee + 1;
      end
    end
    f = x[55:3];
    if (ee > 1023) begin
      of = 1'b1;
      ix = 1'b1;
      r = (md == 2'b00 || toward) ? {s, 11'h7FF, 52'd0} : {s, 11'h7FE, {52{1'b1}}};
    end else if (!f[52]) begin
      r = {s, 11'd0, f[51:0]};
    end else begin
      r = {s, 11'(ee + 1023), f[51:0]};
    end
    return {r, ix, uf, of};
  endfunction

  function automatic logic [55:0] next_mant();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return {1'b1, seed[54:0]};
  endfunction

  task automatic cmp(input string req, input logic [66:0] got, input logic [66:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h flags %b, expected %h flags %b",
               req, got[66:3], got[2:0], exp[66:3], exp[2:0]);
    end
  endtask

  task automatic drive(input logic s, input int e, input logic [55:0] m,
                       input logic [1:0] md, input logic fz);
    @(negedge clk_i);
    sign_i = s; exp_i = 13'(e); mant_i = m; rmode_i = md; ftz_i = fz;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (!valid_o) begin
      checks++;
      errors++;
      $display("FAIL R2: valid_o got 0 expected 1");
    end
  endtask

  task automatic run_ref(input string req, input logic s, input int e, input logic [55:0] m,
                         input logic [1:0] md, input logic fz);
    drive(s, e, m, md, fz);
    cmp(req, {result_o, inexact_o, underflow_o, overflow_o}, ref_dp(s, e, m, md, fz));
  endtask

  task automatic run_hand(input string req, input logic s, input int e, input logic [55:0] m,
                          input logic [1:0] md, input logic fz,
                          input logic [63:0] w, input logic [2:0] fl);
    drive(s, e, m, md, fz);
    cmp(req, {result_o, inexact_o, underflow_o, overflow_o}, {w, fl});
  endtask

  task automatic t_reset();
    valid_i = 1'b1;
    mant_i  = 56'h80000000000000;
    repeat (3) @(negedge clk_i);
    cmp("R1", {result_o, inexact_o, underflow_o, overflow_o}, 67'd0);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid_o got %b expected 0", valid_o);
    end
    valid_i = 1'b0;
    rst_ni  = 1'b1;
  endtask

  task automatic t_latency();
    drive(1'b0, 0, 56'h80000000000000, 2'b00, 1'b0);
    cmp("R2", {result_o, inexact_o, underflow_o, overflow_o}, {64'h3FF0000000000000, 3'b000});
    @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R2: idle valid_o got %b expected 0", valid_o);
    end
  endtask

  task automatic t_exact();
    run_hand("R10", 1'b1, 1, 56'hA0000000000000, 2'b00, 1'b0, 64'hC004000000000000, 3'b000);
    run_hand("R5", 1'b0, 1023, 56'hFFFFFFFFFFFFF8, 2'b01, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b000);
    run_hand("R5", 1'b0, -1022, 56'h80000000000000, 2'b11, 1'b0, 64'h0010000000000000, 3'b000);
    run_hand("R8", 1'b1, -1022, 56'h80000000000000, 2'b10, 1'b1, 64'h8010000000000000, 3'b000);
  endtask

  task automatic t_round();
    run_hand("R3", 1'b0, 0, 56'h80000000000004, 2'b00, 1'b0, 64'h3FF0000000000000, 3'b100);
    run_hand("R3", 1'b0, 0, 56'h8000000000000C, 2'b00, 1'b0, 64'h3FF0000000000002, 3'b100);
    run_hand("R3", 1'b0, 0, 56'h80000000000001, 2'b10, 1'b0, 64'h3FF0000000000001, 3'b100);
    run_hand("R3", 1'b1, 0, 56'h80000000000001, 2'b10, 1'b0, 64'hBFF0000000000000, 3'b100);
    run_hand("R3", 1'b1, 0, 56'h80000000000001, 2'b11, 1'b0, 64'hBFF0000000000001, 3'b100);
    run_hand("R3", 1'b0, 0, 56'h80000000000007, 2'b01, 1'b0, 64'h3FF0000000000000, 3'b100);
    for (int i = 0; i < 24; i++)
      for (int md = 0; md < 4; md++)
        for (int s = 0; s < 2; s++)
          run_ref("R3", 1'(s), (i * 37) % 200 - 100, next_mant(), 2'(md), 1'b0);
  endtask

  task automatic t_carry();
    run_hand("R4", 1'b0, 0, 56'hFFFFFFFFFFFFFC, 2'b00, 1'b0, 64'h4000000000000000, 3'b100);
    run_hand("R4", 1'b1, 5, 56'hFFFFFFFFFFFFF9, 2'b11, 1'b0, 64'hC050000000000000, 3'b100);
    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 2; s++)
        run_ref("R4", 1'(s), 10, 56'hFFFFFFFFFFFFFF, 2'(md), 1'b0);
  endtask

  task automatic t_ovf();
    run_hand("R9", 1'b0, 1024, 56'h80000000000001, 2'b00, 1'b0, 64'h7FF0000000000000, 3'b101);
    run_hand("R9", 1'b1, 1024, 56'h80000000000001, 2'b00, 1'b0, 64'hFFF0000000000000, 3'b101);
    run_hand("R9", 1'b0, 1024, 56'h80000000000001, 2'b01, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b101);
    run_hand("R9", 1'b1, 1024, 56'h80000000000001, 2'b01, 1'b0, 64'hFFEFFFFFFFFFFFFF, 3'b101);
    run_hand("R9", 1'b0, 1024, 56'h80000000000001, 2'b10, 1'b0, 64'h7FF0000000000000, 3'b101);
    run_hand("R9", 1'b1, 1024, 56'h80000000000001, 2'b10, 1'b0, 64'hFFEFFFFFFFFFFFFF, 3'b101);
    run_hand("R9", 1'b0, 1024, 56'h80000000000001, 2'b11, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b101);
    run_hand("R9", 1'b1, 1024, 56'h80000000000001, 2'b11, 1'b0, 64'hFFF0000000000000, 3'b101);
    run_hand("R9", 1'b0, 1023, 56'hFFFFFFFFFFFFFF, 2'b00, 1'b0, 64'h7FF0000000000000, 3'b101);
    run_hand("R9", 1'b0, 1023, 56'hFFFFFFFFFFFFFF, 2'b01, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b100);
  endtask

  task automatic t_denorm();
    run_hand("R6", 1'b0, -1023, 56'h80000000000000, 2'b00, 1'b0, 64'h0008000000000000, 3'b000);
    run_hand("R6", 1'b0, -1100, 56'h80000000000000, 2'b00, 1'b0, 64'h0000000000000000, 3'b110);
    run_hand("R6", 1'b0, -1100, 56'h80000000000000, 2'b10, 1'b0, 64'h0000000000000001, 3'b110);
    run_hand("R10", 1'b1, -1024, 56'hC0000000000000, 2'b01, 1'b0, 64'h8006000000000000, 3'b000);
    for (int d = 1; d <= 60; d++)
      for (int md = 0; md < 4; md++)
        run_ref("R6", 1'(d & 1), -1022 - d, next_mant(), 2'(md), 1'b0);
  endtask

  task automatic t_edge();
    run_hand("R7", 1'b0, -1023, 56'hFFFFFFFFFFFFFF, 2'b00, 1'b0, 64'h0010000000000000, 3'b100);
    run_hand("R7", 1'b0, -1023, 56'hFFFFFFFFFFFFFF, 2'b01, 1'b0, 64'h000FFFFFFFFFFFFF, 3'b110);
    run_hand("R7", 1'b1, -1023, 56'hFFFFFFFFFFFFFF, 2'b10, 1'b0, 64'h800FFFFFFFFFFFFF, 3'b110);
    run_hand("R7", 1'b1, -1023, 56'hFFFFFFFFFFFFFF, 2'b11, 1'b0, 64'h8010000000000000, 3'b100);
    run_hand("R7", 1'b0, -1023, 56'hFFFFFFFFFFFFF9, 2'b00, 1'b0, 64'h0010000000000000, 3'b110);
  endtask

  task automatic t_ftz();
    run_hand("R8", 1'b0, -1050, 56'hC1234567890ABC, 2'b00, 1'b1, 64'h0000000000000000, 3'b110);
    run_hand("R8", 1'b1, -1050, 56'hC1234567890ABC, 2'b00, 1'b1, 64'h8000000000000000, 3'b110);
    run_hand("R8", 1'b0, -1050, 56'hC1234567890ABC, 2'b01, 1'b1, 64'h0000000000000000, 3'b110);
    run_hand("R8", 1'b1, -1050, 56'hC1234567890ABC, 2'b01, 1'b1, 64'h8000000000000000, 3'b110);
    run_hand("R8", 1'b0, -1050, 56'hC1234567890ABC, 2'b10, 1'b1, 64'h0000000000000001, 3'b110);
    run_hand("R8", 1'b1, -1050, 56'hC1234567890ABC, 2'b10, 1'b1, 64'h8000000000000000, 3'b110);
    run_hand("R8", 1'b0, -1050, 56'hC1234567890ABC, 2'b11, 1'b1, 64'h0000000000000000, 3'b110);
    run_hand("R8", 1'b1, -1050, 56'hC1234567890ABC, 2'b11, 1'b1, 64'h8000000000000001, 3'b110);
    run_hand("R8", 1'b0, -1023, 56'hFFFFFFFFFFFFFF, 2'b00, 1'b1, 64'h0000000000000000, 3'b110);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_exact();
    t_round();
    t_carry();
    t_ovf();
    t_denorm();
    t_edge();
    t_ftz();
    repeat (2) @(negedge clk_i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule